// File: doc/BRIEF.md
# Single-Cycle Accumulator CPU Core

This block is a 16-bit processor core that completes one instruction per clock. Each clock it reads an instruction word from instruction memory and a data word from data memory. The instruction word itself carries every control signal the core needs. The core holds three registers:

- an address/constant register (A),
- a data register (D),
- a program counter (PC).

Instruction memory and data memory sit outside the block. The fetch address output drives the instruction memory. The data address output drives the data memory.

There are two kinds of instruction, chosen by the top bit:

- **Constant-load:** places the whole word into A.
- **Compute:** runs a six-control-bit ALU on D and a second operand, sends the result to any subset of A, D and data memory, and may branch. A branch happens when a three-bit condition mask matches the sign of the ALU result. The branch target is the current value of A.

Every interface of this core is a plain per-cycle signal. The memories answer combinationally within the cycle, so there is no valid/ready handshake and no back-pressure. Reset holds the core at fetch address 0.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, PC, A and D are cleared to 0; after that edge `fetch_addr` and `mem_addr` read 0.
- R2: An instruction with bit 15 = 0 is a constant-load: after the edge A holds the full 16-bit instruction word, `mem_we` is 0, and the PC advances by one whatever bits 2..0 contain.
- R3: For a compute instruction (bit 15 = 1), bit 12 selects the ALU second operand: 0 selects A, 1 selects `mem_rdata`; the first operand is always D.
- R4: ALU control is bits 11..6, MSB first: zero-x, invert-x, zero-y, invert-y, function (1 = add, 0 = bitwise AND), invert-output. They apply in that order, and the result appears on `mem_wdata` in the same cycle.
- R5: Destination bits 5, 4, 3 enable writes of the ALU result to A, D and memory respectively. `mem_we` equals bit 15 AND bit 3.
- R6: Condition bits 2, 1, 0 mean less-than-zero, equal-zero and greater-than-zero on the ALU result. If a set bit matches the result of a compute instruction, the PC loads A[14:0] as it stood before the edge.
- R7: When no branch is taken and reset is low, the PC increments by one and wraps from 0x7FFF to 0.
- R8: Bits 14 and 13 have no effect on any output or register.
- R9: `mem_addr` is A[14:0] before the edge. An instruction that both writes A and branches jumps to the old A, and the new A is seen only on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 16 | Instruction read at `fetch_addr` |
| mem_rdata | input | 16 | Data memory read value at `mem_addr` |
| mem_wdata | output | 16 | ALU result, value to store to data memory |
| mem_we | output | 1 | Data memory write enable |
| mem_addr | output | 15 | Data memory address (A[14:0]) |
| fetch_addr | output | 15 | Address of the instruction being executed |

## Verification
A register write to A and a branch can land on the same clock edge. Both use A: the branch reads it as its target, while the destination field overwrites it. The bench loads a known constant into A, then issues a compute instruction that writes all-ones into A and jumps unconditionally. It expects the fetch address to become the old constant and `mem_addr` to show 0x7FFF only on the following cycle. A memory store that also rewrites A is judged the same way: it must address the old A.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int WORD_W = 16;

  // ALU control, MSB first as carried in the instruction
  typedef struct packed {
    logic zero_x;
    logic inv_x;
    logic zero_y;
    logic inv_y;
    logic add_sel;
    logic inv_out;
  } alu_ctl_t;

  // Decoded instruction fields
  typedef struct packed {
    logic     is_compute;
    logic     y_from_mem;
    alu_ctl_t alu_ctl;
    logic     wr_a;
    logic     wr_d;
    logic     wr_m;
    logic     on_neg;
    logic     on_zero;
    logic     on_pos;
  } ctl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_core_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] instr,
  output ctl_t         ctl
);
  localparam int OP_BIT  = W - 1;
  localparam int SEL_BIT = W - 4;
  localparam int FN_LO   = 6;
  localparam int DST_LO  = 3;

  logic unused_spare_bits;
  assign unused_spare_bits = ^instr[OP_BIT-1:SEL_BIT+1];

  always_comb begin
    ctl.is_compute = instr[OP_BIT];
    ctl.y_from_mem = instr[SEL_BIT];
    ctl.alu_ctl    = alu_ctl_t'(instr[FN_LO+5:FN_LO]);
    ctl.wr_a       = instr[OP_BIT] & instr[DST_LO+2];
    ctl.wr_d       = instr[OP_BIT] & instr[DST_LO+1];
    ctl.wr_m       = instr[OP_BIT] & instr[DST_LO];
    ctl.on_neg     = instr[OP_BIT] & instr[2];
    ctl.on_zero    = instr[OP_BIT] & instr[1];
    ctl.on_pos     = instr[OP_BIT] & instr[0];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  alu_ctl_t     ctl,
  output logic [W-1:0] result,
  output logic         zr,
  output logic         ng
);
  logic [W-1:0] x_z, x_p, y_z, y_p, f_out;

  always_comb begin
    x_z   = ctl.zero_x ? '0 : x_in;
    x_p   = ctl.inv_x  ? ~x_z : x_z;
    y_z   = ctl.zero_y ? '0 : y_in;
    y_p   = ctl.inv_y  ? ~y_z : y_z;
    f_out = ctl.add_sel ? (x_p + y_p) : (x_p & y_p);
    result = ctl.inv_out ? ~f_out : f_out;
  end

  assign zr = (result == '0);
  assign ng = result[W-1];
endmodule

// File: rtl/acc_branch.sv
module acc_branch
  import acc_core_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic          zr,
  input  logic          ng,
  input  logic [AW-1:0] target,
  output logic          take,
  output logic [AW-1:0] pc
);
  logic          pos;
  logic [AW-1:0] pc_q;

  assign pos  = ~zr & ~ng;
  assign take = (ctl.on_neg & ng) | (ctl.on_zero & zr) | (ctl.on_pos & pos);

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (take) pc_q <= target;
    else           pc_q <= pc_q + AW'(1);
  end

  assign pc = pc_q;

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc_q == $past(pc_q) + AW'(1));

  // R6
  taken_needs_compute_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> ctl.is_compute);
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_core_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [15:0]  instr_word,
  input  logic [15:0]  mem_rdata,
  output logic [15:0]  mem_wdata,
  output logic         mem_we,
  output logic [14:0]  mem_addr,
  output logic [14:0]  fetch_addr
);
  localparam int AW = W - 1;

  ctl_t         ctl;
  logic [W-1:0] a_q, d_q, y_op, alu_res;
  logic         zr, ng, take;

  acc_decode #(.W(W)) u_dec (.instr(instr_word), .ctl(ctl));

  assign y_op = ctl.y_from_mem ? mem_rdata : a_q;

  acc_alu #(.W(W)) u_alu (
    .x_in(d_q), .y_in(y_op), .ctl(ctl.alu_ctl),
    .result(alu_res), .zr(zr), .ng(ng)
  );

  acc_branch #(.AW(AW)) u_br (
    .clk(clk), .rst(rst), .ctl(ctl), .zr(zr), .ng(ng),
    .target(a_q[AW-1:0]), .take(take), .pc(fetch_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)                  a_q <= '0;
    else if (!ctl.is_compute) a_q <= instr_word;
    else if (ctl.wr_a)        a_q <= alu_res;
  end

  always_ff @(posedge clk) begin
    if (rst)           d_q <= '0;
    else if (ctl.wr_d) d_q <= alu_res;
  end

  assign mem_wdata = alu_res;
  assign mem_we    = ctl.wr_m;
  assign mem_addr  = a_q[AW-1:0];

  // R2
  const_load_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_word[W-1] |=> a_q == $past(instr_word));

  // R5
  store_only_compute_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> instr_word[W-1]);

  // R9
  jump_old_a_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> fetch_addr == $past(a_q[AW-1:0]));

  // R5
  d_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.wr_d |=> $stable(d_q));
endmodule

// File: tb/tb_acc_cpu_core.sv
`timescale 1ns/1ps
module tb_acc_cpu_core;
  logic clk = 0, rst = 1;
  logic [15:0] instr_word = '0, mem_rdata = '0, mem_wdata;
  logic mem_we;
  logic [14:0] mem_addr, fetch_addr;

  acc_cpu_core dut (.clk(clk), .rst(rst), .instr_word(instr_word), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_addr(mem_addr), .fetch_addr(fetch_addr));

  always #4 clk = ~clk;

  typedef struct {
    logic [15:0] wdata; logic we; logic [14:0] addr; logic [14:0] pc;
    bit chk_w; string req;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] mA, mD;
  logic [14:0] mPC;

  function automatic logic [15:0] cins(input logic [1:0] x, input logic a,
      input logic [5:0] c, input logic [2:0] d, input logic [2:0] j);
    return {1'b1, x, a, c, d, j};
  endfunction

  function automatic logic [15:0] ref_alu(input logic [15:0] xv, input logic [15:0] yv,
      input logic [5:0] c);
    logic [15:0] r;
    if (c[5]) xv = 16'h0;
    if (c[4]) xv = ~xv;
    if (c[3]) yv = 16'h0;
    if (c[2]) yv = ~yv;
    r = c[1] ? xv + yv : xv & yv;
    if (c[0]) r = ~r;
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act,
      input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] ins, input logic [15:0] mval, input string req);
    exp_t e;
    logic [15:0] r;
    logic jmp;
    @(negedge clk); #1;
    rst = 0; instr_word = ins; mem_rdata = mval;
    r = ref_alu(mD, ins[12] ? mval : mA, ins[11:6]);
    e.wdata = r; e.we = ins[15] & ins[3]; e.addr = mA[14:0]; e.pc = mPC;
    e.chk_w = ins[15]; e.req = req;
    q.push_back(e);
    jmp = ins[15] && ((ins[2] && r[15]) || (ins[1] && r == 0) || (ins[0] && !r[15] && r != 0));
    mPC = jmp ? mA[14:0] : mPC + 15'd1;
    if (ins[15] && ins[4]) mD = r;
    if (!ins[15]) mA = ins; else if (ins[5]) mA = r;
  endtask

  task automatic do_reset();
    exp_t e;
    @(negedge clk); #1;
    rst = 1; instr_word = 16'h0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); #1;
    mA = 0; mD = 0; mPC = 0;
    e.wdata = 0; e.we = 0; e.addr = 0; e.pc = 0; e.chk_w = 0; e.req = "R1";
    q.push_back(e);
  endtask

  // monitor / scoreboard
  initial forever begin
    exp_t e;
    @(negedge clk); #3;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.req, "fetch_addr", {1'b0, fetch_addr}, {1'b0, e.pc});
      check(e.req, "mem_addr", {1'b0, mem_addr}, {1'b0, e.addr});
      check(e.req, "mem_we", {15'd0, mem_we}, {15'd0, e.we});
      if (e.chk_w) check(e.req, "mem_wdata", mem_wdata, e.wdata);
    end
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(16'd5, 0, "R2");
    step(cins(2'b11, 0, 6'b110000, 3'b010, 3'b000), 0, "R3");      // D=A
    step(16'd3, 0, "R2");
    step(cins(2'b11, 0, 6'b000010, 3'b010, 3'b000), 0, "R4");      // D=D+A
    step(cins(2'b11, 0, 6'b001100, 3'b001, 3'b000), 0, "R5");      // M=D
    step(cins(2'b11, 1, 6'b110111, 3'b101, 3'b000), 16'd100, "R3"); // AM=M+1, old addr R9
    step(cins(2'b11, 0, 6'b010011, 3'b001, 3'b000), 0, "R4");      // M=D-A
    step(cins(2'b11, 0, 6'b000000, 3'b001, 3'b000), 0, "R4");      // D&A
    step(cins(2'b11, 0, 6'b010101, 3'b001, 3'b000), 0, "R4");      // D|A
    step(cins(2'b11, 0, 6'b001111, 3'b001, 3'b000), 0, "R4");      // -D
    step(cins(2'b11, 0, 6'b110010, 3'b001, 3'b000), 0, "R4");      // A-1
    step(cins(2'b11, 1, 6'b000111, 3'b001, 3'b000), 16'h1234, "R3"); // M-D
    step(cins(2'b11, 0, 6'b101010, 3'b001, 3'b000), 0, "R4");      // 0
    step(cins(2'b11, 0, 6'b111010, 3'b001, 3'b000), 0, "R4");      // -1
    step(cins(2'b11, 0, 6'b111111, 3'b001, 3'b000), 0, "R4");      // 1
    step(cins(2'b11, 0, 6'b001101, 3'b011, 3'b000), 0, "R5");      // DM=!D
    step(16'd40, 0, "R2");
    step(cins(2'b11, 0, 6'b111111, 3'b000, 3'b001), 0, "R6");      // 1;JGT taken
    step(cins(2'b11, 0, 6'b101010, 3'b000, 3'b010), 0, "R6");      // 0;JEQ taken
    step(cins(2'b11, 0, 6'b111010, 3'b000, 3'b100), 0, "R6");      // -1;JLT taken
    step(cins(2'b11, 0, 6'b111111, 3'b000, 3'b100), 0, "R7");      // 1;JLT not
    step(cins(2'b11, 0, 6'b101010, 3'b000, 3'b101), 0, "R7");      // 0;JNE not
    step(cins(2'b11, 0, 6'b111010, 3'b000, 3'b011), 0, "R7");      // -1;JGE not
    step(cins(2'b11, 0, 6'b101010, 3'b000, 3'b111), 0, "R6");      // 0;JMP taken
    step(cins(2'b11, 0, 6'b111010, 3'b000, 3'b101), 0, "R6");      // -1;JNE taken
    step(cins(2'b11, 0, 6'b101010, 3'b000, 3'b000), 0, "R7");      // no cond
    step(16'h0007, 0, "R2");                                       // constant never jumps
    step(16'd50, 0, "R2");
    step(cins(2'b11, 0, 6'b111010, 3'b100, 3'b111), 0, "R9");      // A=-1;JMP to old A
    step(cins(2'b11, 0, 6'b101010, 3'b001, 3'b000), 0, "R9");      // new A visible now
    step(cins(2'b00, 0, 6'b111111, 3'b011, 3'b000), 0, "R8");
    step(cins(2'b01, 0, 6'b011111, 3'b011, 3'b000), 0, "R8");
    step(cins(2'b10, 1, 6'b000010, 3'b001, 3'b010), 16'h0003, "R8");
    step(16'h7FFF, 0, "R2");
    step(cins(2'b11, 0, 6'b101010, 3'b000, 3'b111), 0, "R6");      // jump to 0x7FFF
    step(16'd1, 0, "R7");                                          // pc wraps next
    step(16'd2, 0, "R7");
    do_reset();
    step(cins(2'b11, 0, 6'b001100, 3'b001, 3'b000), 0, "R1");      // D cleared
    @(negedge clk); @(negedge clk); #5;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule